// File: doc/BRIEF.md
# Packed Condition Code Evaluator

This block decides whether a conditional operation should run. Earlier logic does not keep the four arithmetic flags (negative, zero, carry, overflow). Instead it keeps a small record: the kind of operation that last set the flags, plus up to three 32-bit operands. This block takes that record and an 8-bit selector. The selector carries a 4-bit condition code in its upper nibble and the 4-bit record kind in its lower nibble. The block works out the flags the record implies, applies the condition to them, and returns a single pass bit zero-extended to a full word.

The block is purely combinational. The always-true condition bypasses flag evaluation completely. The illegal condition code raises an error output, and so does an unknown record kind. Conditions come in pairs: the even code of each pair is the base test, and the odd code is its inverse.

Top module: `cond_eval`

## Requirements
- R1: `sel_i[7:4]` is the condition code and `sel_i[3:0]` is the record kind. The record kind encoding is: 0 = copy, 1 = add, 2 = add-with-carry, 3 = subtract, 4 = subtract-with-borrow, 5 = logic, 6 = multiply, 7 = long multiply.
- R2: Condition code 14 (always) gives `pass_o` = 1 and `err_o` = 0. This holds for every record kind and every operand value, including record kinds that are not defined.
- R3: Condition code 15 (never/illegal) gives `err_o` = 1 and `pass_o` = 0.
- R4: A record kind of 8 to 15, paired with any condition code other than 14, gives `err_o` = 1 and `pass_o` = 0.
- R5: Bits 31:1 of `pass_o` are zero for every input.
- R6: Each even condition code 2k is a base test, and code 2k+1 passes exactly when 2k fails. The base tests are:
  - 0: Z
  - 2: C
  - 4: N
  - 6: V
  - 8: C and not Z
  - 10: N equals V
  - 12: not Z and N equals V
- R7: Copy record: N, Z, C and V are operand A bits 31, 30, 29 and 28 respectively.
- R8: Add record: the result is A+B. Add-with-carry record: the result is A+B+cin, where cin is bit 0 of operand C. In both cases N is result bit 31, Z means the 32-bit result is zero, C is the unsigned carry out, and V is signed overflow.
- R9: Subtract record: the result is A−B. C is set when A ≥ B unsigned. V is signed overflow of the subtraction. N and Z come from the result.
- R10: Subtract-with-borrow record: the result is A−B−(1−cin), where cin is bit 0 of operand C. C is (A ≥ B) when cin = 1 and (A > B) when cin = 0. V is signed overflow. N and Z come from the result.
- R11: Logic record and multiply record: N and Z come from operand A. For the logic record, C is bit 0 of operand B and V is bit 0 of operand C. For the multiply record, C is bit 1 of operand C and V is bit 0 of operand C.
- R12: Long multiply record: N is bit 31 of operand B. Z means A and B are both zero. C is bit 1 of operand C and V is bit 0 of operand C.
- R13: For add-with-carry and subtract-with-borrow, only bit 0 of operand C acts as the carry input; bits 31:1 of operand C have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sel_i | input | 8 | Condition code (7:4) and record kind (3:0) |
| opa_i | input | 32 | Record operand A |
| opb_i | input | 32 | Record operand B |
| opc_i | input | 32 | Record operand C (carry / saved flags) |
| pass_o | output | 32 | Condition result in bit 0; bits 31:1 are zero |
| err_o | output | 1 | Illegal condition code or unknown record kind |

## Verification
The bench runs every condition code from 0 to 13 against each record kind. It uses operand sets chosen to sit at the carry and overflow edges:
- equal operands, which separate the two carry rules of subtract-with-borrow;
- 0x7FFFFFFF + 1, which overflows;
- 0xFFFFFFFF + 1, which carries out to zero.

If the inversion bit were misused, a whole pair would flip. If carry-in were mishandled, the borrow case would disagree at A = B. If the long multiply record took N from the wrong word, the mixed-sign vectors would fail. The bench also drives the always-true code with undefined record kinds, checking that it does not raise an error. It sets garbage in the upper bits of operand C, checking that they leave the carry unchanged.

// File: rtl/cond_eval.sv
module cond_eval #(
  parameter int DATA_W = 32
) (
  input  logic [7:0]        sel_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] opc_i,
  output logic [DATA_W-1:0] pass_o,
  output logic              err_o
);
  localparam int MSB = DATA_W - 1;

  localparam logic [3:0] K_COPY = 4'd0;
  localparam logic [3:0] K_ADD  = 4'd1;
  localparam logic [3:0] K_ADC  = 4'd2;
  localparam logic [3:0] K_SUB  = 4'd3;
  localparam logic [3:0] K_SBB  = 4'd4;
  localparam logic [3:0] K_LOG  = 4'd5;
  localparam logic [3:0] K_MUL  = 4'd6;
  localparam logic [3:0] K_MULL = 4'd7;

  localparam logic [3:0] CC_ALWAYS = 4'd14;
  localparam logic [3:0] CC_NEVER  = 4'd15;

  logic [3:0] cc, kind;
  assign cc   = sel_i[7:4];
  assign kind = sel_i[3:0];

  logic cin;
  assign cin = opc_i[0];

  // One shared adder serves all four arithmetic record kinds.
  logic [DATA_W-1:0] addend;
  logic              add_cin;
  always_comb begin
    addend  = opb_i;
    add_cin = 1'b0;
    case (kind)
      K_ADD: begin addend = opb_i;  add_cin = 1'b0; end
      K_ADC: begin addend = opb_i;  add_cin = cin;  end
      K_SUB: begin addend = ~opb_i; add_cin = 1'b1; end
      K_SBB: begin addend = ~opb_i; add_cin = cin;  end
      default: ;
    endcase
  end

  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] res;
  logic              ovf;
  assign sum = {1'b0, opa_i} + {1'b0, addend} + {{DATA_W{1'b0}}, add_cin};
  assign res = sum[MSB:0];
  assign ovf = (res[MSB] ^ opa_i[MSB]) & (res[MSB] ^ addend[MSB]);

  logic fn, fz, fc, fv, kind_ok;
  always_comb begin
    fn = 1'b0; fz = 1'b0; fc = 1'b0; fv = 1'b0; kind_ok = 1'b1;
    case (kind)
      K_COPY: begin
        fn = opa_i[MSB];   fz = opa_i[MSB-1];
        fc = opa_i[MSB-2]; fv = opa_i[MSB-3];
      end
      K_ADD, K_ADC, K_SUB, K_SBB: begin
        fn = res[MSB]; fz = (res == '0); fc = sum[DATA_W]; fv = ovf;
      end
      K_LOG: begin
        fn = opa_i[MSB]; fz = (opa_i == '0); fc = opb_i[0]; fv = opc_i[0];
      end
      K_MUL: begin
        fn = opa_i[MSB]; fz = (opa_i == '0); fc = opc_i[1]; fv = opc_i[0];
      end
      K_MULL: begin
        fn = opb_i[MSB]; fz = ((opa_i | opb_i) == '0);
        fc = opc_i[1];   fv = opc_i[0];
      end
      default: kind_ok = 1'b0;
    endcase
  end

  logic base;
  always_comb begin
    case (cc[3:1])
      3'd0:    base = fz;
      3'd1:    base = fc;
      3'd2:    base = fn;
      3'd3:    base = fv;
      3'd4:    base = fc & ~fz;
      3'd5:    base = ~(fn ^ fv);
      3'd6:    base = ~(fz | (fn ^ fv));
      default: base = 1'b0;
    endcase
  end

  logic hit;
  assign err_o  = (cc == CC_NEVER) | ((cc != CC_ALWAYS) & ~kind_ok);
  assign hit    = (cc == CC_ALWAYS) | (~err_o & (base ^ cc[0]));
  assign pass_o = {{(DATA_W-1){1'b0}}, hit};

  always_comb begin
    AST_UPPER_ZERO: assert (pass_o[MSB:1] == '0) else $error("upper bits set"); // R5
    AST_ERR_CLEARS: assert (!err_o || pass_o == '0) else $error("error with pass"); // R4
    if (cc == CC_ALWAYS) begin
      AST_ALWAYS_PASS: assert (pass_o[0] && !err_o) else $error("always failed"); // R2
    end
    if (cc == CC_NEVER) begin
      AST_NEVER_ERR: assert (err_o) else $error("never not flagged"); // R3
    end
    if (kind == K_SBB && cc == 4'd2) begin
      AST_SBB_HS: assert (pass_o[0] == (cin ? (opb_i <= opa_i) : (opb_i < opa_i)))
        else $error("carry after borrow"); // R10
    end
  end
endmodule

// File: tb/cond_eval_tb.sv
module cond_eval_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]  sel;
  logic [31:0] a, b, c;
  logic [31:0] pass;
  logic        err;

  cond_eval dut_i (.sel_i(sel), .opa_i(a), .opb_i(b), .opc_i(c), .pass_o(pass), .err_o(err));

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  function automatic bit ref_cond(input int code, input bit n, z, cf, v);
    case (code)
      0: return z;          1: return !z;
      2: return cf;         3: return !cf;
      4: return n;          5: return !n;
      6: return v;          7: return !v;
      8: return cf && !z;   9: return !cf || z;
      10: return n == v;    11: return n != v;
      12: return !z && n == v; 13: return z || n != v;
      default: return 1'b0;
    endcase
  endfunction

  // Reference flags computed with wide signed/unsigned arithmetic.
  function automatic void ref_flags(input int k, input logic [31:0] ra, rb, rc,
                                    output bit n, z, cf, v);
    longint ua = {32'd0, ra}, ub = {32'd0, rb};
    longint sa = longint'($signed(ra)), sb = longint'($signed(rb));
    longint ci = longint'(rc[0]);
    longint sr = 0, ur = 0;
    n = 0; z = 0; cf = 0; v = 0;
    case (k)
      0: begin n = ra[31]; z = ra[30]; cf = ra[29]; v = ra[28]; end
      1, 2: begin
        if (k == 1) ci = 0;
        ur = ua + ub + ci; sr = sa + sb + ci;
        cf = ur > 64'hFFFF_FFFF;
      end
      3, 4: begin
        if (k == 3) ci = 1;
        ur = ua - ub - (1 - ci); sr = sa - sb - (1 - ci);
        cf = (ci == 1) ? (ua >= ub) : (ua > ub);
      end
      5: begin n = ra[31]; z = ra == 0; cf = rb[0]; v = rc[0]; end
      6: begin n = ra[31]; z = ra == 0; cf = rc[1]; v = rc[0]; end
      7: begin n = rb[31]; z = (ra == 0) && (rb == 0); cf = rc[1]; v = rc[0]; end
      default: ;
    endcase
    if (k >= 1 && k <= 4) begin
      logic [31:0] r32 = ur[31:0];
      n = r32[31]; z = r32 == 0;
      v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    end
  endfunction

  task automatic check(input string req, input int code, input int k,
                       input logic [31:0] ta, tb, tc);
    bit n, z, cf, v, ep, ee;
    @(negedge clk);
    sel = {code[3:0], k[3:0]}; a = ta; b = tb; c = tc;
    #1;
    if (code == 14) begin ep = 1; ee = 0; end
    else if (code == 15 || k > 7) begin ep = 0; ee = 1; end
    else begin ref_flags(k, ta, tb, tc, n, z, cf, v); ep = ref_cond(code, n, z, cf, v); ee = 0; end
    checks++;
    if (pass !== {31'd0, ep} || err !== ee) begin
      errors++;
      $display("FAIL %s cond=%0d kind=%0d a=%h b=%h c=%h: pass=%h err=%b expected pass=%h err=%b",
               req, code, k, ta, tb, tc, pass, err, {31'd0, ep}, ee);
    end
  endtask

  task automatic sweep(input string req, input int k, input logic [31:0] ta, tb, tc);
    for (int cc = 0; cc < 14; cc++) check(req, cc, k, ta, tb, tc);
  endtask

  task automatic t_reset;
    check("R1 idle", 0, 0, 32'd0, 32'd0, 32'd0);
  endtask

  task automatic t_copy; // R7 R6
    for (int f = 0; f < 16; f++) sweep("R7/R6 copy", 0, {f[3:0], 28'h5A5A5A5}, 32'hFFFF_FFFF, 32'd3);
  endtask

  task automatic t_add; // R8
    sweep("R8 add", 1, 32'h7FFF_FFFF, 32'd1, 32'd0);
    sweep("R8 add", 1, 32'hFFFF_FFFF, 32'd1, 32'd0);
    sweep("R8 add", 1, 32'h8000_0000, 32'h8000_0000, 32'd1);
    sweep("R8 add", 1, 32'd5, 32'd7, 32'd0);
    sweep("R8 adc", 2, 32'hFFFF_FFFF, 32'd0, 32'd1);
    sweep("R8 adc", 2, 32'h7FFF_FFFE, 32'd1, 32'd1);
    sweep("R8 adc", 2, 32'd0, 32'd0, 32'd0);
  endtask

  task automatic t_sub; // R9
    sweep("R9 sub", 3, 32'd9, 32'd9, 32'd0);
    sweep("R9 sub", 3, 32'd3, 32'd9, 32'd0);
    sweep("R9 sub", 3, 32'h8000_0000, 32'd1, 32'd0);
    sweep("R9 sub", 3, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'd0);
  endtask

  task automatic t_sbb; // R10 R13
    sweep("R10 sbb", 4, 32'd9, 32'd9, 32'd1);
    sweep("R10 sbb", 4, 32'd9, 32'd9, 32'd0);
    sweep("R10 sbb", 4, 32'd10, 32'd9, 32'd0);
    sweep("R10 sbb", 4, 32'h8000_0000, 32'd0, 32'd0);
    sweep("R13 sbb upper c", 4, 32'd9, 32'd9, 32'hFFFF_FFFE);
    sweep("R13 adc upper c", 2, 32'hFFFF_FFFF, 32'd0, 32'h8000_0000);
  endtask

  task automatic t_logic_mul; // R11 R12
    sweep("R11 logic", 5, 32'h8000_0001, 32'd1, 32'd0);
    sweep("R11 logic", 5, 32'd0, 32'd0, 32'd1);
    sweep("R11 mul", 6, 32'h1234_5678, 32'd0, 32'd2);
    sweep("R11 mul", 6, 32'd0, 32'hFFFF_FFFF, 32'd1);
    sweep("R12 mull", 7, 32'h8000_0000, 32'd1, 32'd3);
    sweep("R12 mull", 7, 32'd1, 32'h8000_0000, 32'd0);
    sweep("R12 mull", 7, 32'd0, 32'd0, 32'd2);
  endtask

  task automatic t_special; // R2 R3 R4 R5
    for (int k = 0; k < 16; k++) check("R2 always", 14, k, 32'hDEAD_BEEF, 32'h1, 32'hFFFF_FFFF);
    for (int k = 0; k < 16; k++) check("R3 never", 15, k, 32'd0, 32'd0, 32'd0);
    for (int k = 8; k < 16; k++) check("R4 bad kind", 0, k, 32'd0, 32'd0, 32'd0);
    check("R4 bad kind", 13, 15, 32'd0, 32'd0, 32'd0);
  endtask

  task automatic t_mixed; // R5 R1
    logic [31:0] s = 32'hACE1_2345;
    for (int i = 0; i < 400; i++) begin
      s = {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
      check("R5/R1 mixed", i % 16, (i / 16) % 9, s, {s[15:0], s[31:16]}, s ^ 32'h5555_5555);
    end
  endtask

  initial begin
    sel = 0; a = 0; b = 0; c = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_copy(); t_add(); t_sub(); t_sbb(); t_logic_mul(); t_special(); t_mixed();
    done = 1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WD_LIMIT && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WD_LIMIT);
      done = 1;
    end
  end

  initial begin
    wait (done);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule